// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter assembled from identical 4-bit stages. Each stage has a rising-edge register, a synchronous preset from a data bus, a count direction select and two active-low count enables. Each stage also has an active-low terminal-count flag that is decoded combinationally from its own state. Inside the wrapper, the flag of each stage drives the carry enable of the next more significant stage. The whole chain therefore acts as one counter of 4·N bits, with no gating between the stages.

Clock, direction, preset and the parallel count enable are shared by all stages. The carry enable reaches only the least significant stage, and the flag of the most significant stage is the block's terminal-count output. An optional synchronous active-high reset clears the count. Its main use is to give simulation a known starting state.

The block moves no data stream, so none of its pins uses valid/ready. Every input is a plain level, sampled at the rising clock edge. The outputs are always valid and cannot be stalled.

Top module: `updn_cascade`

## Requirements
- R1: The count output changes only on a rising clock edge, and all of its bits update on that same edge. A change on any input between edges leaves the count unchanged.
- R2: While `load_n` is 0 (and the reset is inactive), the next rising edge copies `load_val` into the count. This happens whatever the levels of both count enables and of the direction input.
- R3: The count changes by one on an edge only when `load_n` is 1 and both `en_par_n` and `en_carry_n` are 0.
- R4: When `up_dn` is 1 the count goes up by one, and the all-ones value wraps to zero. When `up_dn` is 0 the count goes down by one, and zero wraps to all ones.
- R5: When `load_n` is 1 and either count enable is 1, the count keeps its value across the edge.
- R6: `tc_n` is 0 only when `en_carry_n` is 0 and one of two conditions holds: the count is all ones with `up_dn` at 1, or the count is zero with `up_dn` at 0. At all other times it is 1. It follows a change of `up_dn` or `en_carry_n` in the same cycle, with no edge in between.
- R7: `tc_n` does not depend on `en_par_n`. With the count and the other inputs held, driving `en_par_n` to 1 leaves `tc_n` unchanged.
- R8: Each 4-bit stage counts only when every less significant stage is at its terminal value, because the terminal flag of one stage drives the carry enable of the next. The chain then counts, wraps and flags exactly like one counter of 4·STAGES bits.
- R9: While `sim_rst` is 1, the next rising edge clears the count to zero. The reset has priority over the preset.
- R10: The reference sequence must hold. The counter is preset to all ones minus 2 and counts up through all ones minus 1, all ones, 0, 1 and 2, with `tc_n` at 0 while the count is all ones. It then holds at 2 with the enables at 1. Counting down, it passes through 1, 0, all ones, all ones minus 1 and all ones minus 2, with `tc_n` at 0 while the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| sim_rst | input | 1 | Synchronous active-high clear to zero; priority over preset |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| load_n | input | 1 | Active-low synchronous preset enable |
| en_par_n | input | 1 | Active-low count enable shared by all stages |
| en_carry_n | input | 1 | Active-low carry enable into the least significant stage; also gates `tc_n` |
| load_val | input | 4·STAGES | Preset value |
| count_q | output | 4·STAGES | Current count |
| tc_n | output | 1 | Active-low terminal-count flag of the most significant stage |

## Verification
The clocked assertions assume that every control input is a defined 0 or 1 at each rising edge. They also assume the reset is held for the first edges, so that every `$past` value refers to a cleared register. The bench meets both conditions. It drives all inputs only on the falling edge, and it asserts `sim_rst` from time zero through the first edges. It then sweeps the complete 8-bit configuration: every preset value, both directions and both carry levels. After that it applies random control patterns that flip the direction exactly when the count sits on a terminal value.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_PRESET = 2'd1,
    OP_STEP = 2'd2,
    OP_KEEP = 2'd3
  } stage_op_e;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic      rst,
  input  logic      load_n,
  input  logic      en_p_n,
  input  logic      en_t_n,
  output stage_op_e op
);
  // priority: clear, preset, step, keep
  always_comb begin
    if (rst)                       op = OP_CLEAR;
    else if (!load_n)              op = OP_PRESET;
    else if (!en_p_n && !en_t_n)   op = OP_STEP;
    else                           op = OP_KEEP;
  end
endmodule

// File: rtl/updn_tc_decode.sv
module updn_tc_decode #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] q,
  input  logic         up,
  input  logic         en_t_n,
  output logic         tc_n
);
  logic at_top;
  logic at_bottom;
  logic at_term;

  always_comb begin
    at_top    = &q;
    at_bottom = ~|q;
    at_term   = up ? at_top : at_bottom;
    tc_n      = ~(at_term & ~en_t_n);
  end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up,
  input  logic         load_n,
  input  logic         en_p_n,
  input  logic         en_t_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc_n
);
  localparam logic [W-1:0] ONE = W'(1);

  stage_op_e   op;
  logic [W-1:0] q_r;
  logic [W-1:0] q_step;

  updn_ctrl u_ctrl (
    .rst    (rst),
    .load_n (load_n),
    .en_p_n (en_p_n),
    .en_t_n (en_t_n),
    .op     (op)
  );

  updn_tc_decode #(.W(W)) u_tc (
    .q      (q_r),
    .up     (up),
    .en_t_n (en_t_n),
    .tc_n   (tc_n)
  );

  always_comb q_step = up ? (q_r + ONE) : (q_r - ONE);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR:  q_r <= '0;
      OP_PRESET: q_r <= d;
      OP_STEP:   q_r <= q_step;
      default:   q_r <= q_r;
    endcase
  end

  assign q = q_r;

  p_clear_r9: assert property (@(posedge clk) rst |=> (q == '0));
  p_preset_r2: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (q == $past(d)));
  p_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (load_n && (en_p_n || en_t_n)) |=> $stable(q));
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_p_n && !en_t_n && up && (&q)) |=> (q == '0));
  p_wrap_dn_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_p_n && !en_t_n && !up && (q == '0)) |=> (&q));
endmodule

// File: rtl/updn_cascade.sv
module updn_cascade
  import updn_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned STAGE_W = NIB_W
) (
  input  logic                        clk,
  input  logic                        sim_rst,
  input  logic                        up_dn,
  input  logic                        load_n,
  input  logic                        en_par_n,
  input  logic                        en_carry_n,
  input  logic [STAGES*STAGE_W-1:0]   load_val,
  output logic [STAGES*STAGE_W-1:0]   count_q,
  output logic                        tc_n
);
  localparam int unsigned TOTAL_W = STAGES * STAGE_W;
  localparam logic [TOTAL_W-1:0] ONE_T = TOTAL_W'(1);

  logic [STAGES:0] carry_n;

  assign carry_n[0] = en_carry_n;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    updn_stage #(.W(STAGE_W)) u_stage (
      .clk    (clk),
      .rst    (sim_rst),
      .up     (up_dn),
      .load_n (load_n),
      .en_p_n (en_par_n),
      .en_t_n (carry_n[k]),
      .d      (load_val[k*STAGE_W +: STAGE_W]),
      .q      (count_q[k*STAGE_W +: STAGE_W]),
      .tc_n   (carry_n[k+1])
    );
  end

  assign tc_n = carry_n[STAGES];

  p_tc_gated_r6: assert property (@(posedge clk) disable iff (sim_rst)
    en_carry_n |-> tc_n);
  p_chain_up_r8: assert property (@(posedge clk) disable iff (sim_rst)
    (load_n && !en_par_n && !en_carry_n && up_dn)
      |=> (count_q == $past(count_q) + ONE_T));
  p_chain_dn_r8: assert property (@(posedge clk) disable iff (sim_rst)
    (load_n && !en_par_n && !en_carry_n && !up_dn)
      |=> (count_q == $past(count_q) - ONE_T));
  p_edge_only_r1: assert property (@(posedge clk) disable iff (sim_rst)
    (load_n && en_par_n) |=> $stable(count_q));
endmodule

// File: tb/updn_cascade_tb.sv
`timescale 1ns/1ps
module updn_cascade_tb_top;
  localparam int STAGES = 2;
  localparam int SW = 4;
  localparam int TW = STAGES * SW;
  localparam logic [TW-1:0] ALL1 = '1;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic sim_rst = 1'b1;
  logic up_dn = 1'b1;
  logic load_n = 1'b1;
  logic en_par_n = 1'b1;
  logic en_carry_n = 1'b1;
  logic [TW-1:0] load_val = '0;
  logic [TW-1:0] count_q;
  logic tc_n;

  int total = 0;
  int bad = 0;
  logic [TW-1:0] mdl = '0;

  always #(CLK_P/2) clk = ~clk;

  updn_cascade #(.STAGES(STAGES), .STAGE_W(SW)) dut_i (
    .clk(clk), .sim_rst(sim_rst), .up_dn(up_dn), .load_n(load_n),
    .en_par_n(en_par_n), .en_carry_n(en_carry_n), .load_val(load_val),
    .count_q(count_q), .tc_n(tc_n)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [TW-1:0] act, input logic [TW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_tc(input logic [TW-1:0] v, input logic up, input logic ec);
    return !(!ec && (up ? (v == ALL1) : (v == '0)));
  endfunction

  // called just after a falling edge
  task automatic step(input logic r, input logic ld, input logic ep,
                      input logic ec, input logic up, input logic [TW-1:0] d);
    string tag;
    sim_rst = r; load_n = ld; en_par_n = ep; en_carry_n = ec; up_dn = up; load_val = d;
    #1;
    chk(count_q == mdl, "R1 no change between edges", count_q, mdl);
    chk(tc_n == exp_tc(mdl, up, ec), ep ? "R7 tc with en_par_n high" : "R6 tc decode",
        TW'(tc_n), TW'(exp_tc(mdl, up, ec)));
    @(posedge clk);
    if (r)               begin mdl = '0; tag = "R9 reset"; end
    else if (!ld)        begin mdl = d; tag = "R2 preset"; end
    else if (!ep && !ec) begin mdl = up ? mdl + 1'b1 : mdl - 1'b1; tag = "R3 R4 R8 count"; end
    else                 tag = "R5 hold";
    @(negedge clk);
    chk(count_q == mdl, tag, count_q, mdl);
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] up_seq [5];
    logic [TW-1:0] dn_seq [5];
    @(negedge clk);
    // reset beats preset (R9)
    step(1, 0, 0, 0, 1, 8'hA5);
    chk(count_q == '0, "R9 reset over preset", count_q, '0);
    step(1, 1, 1, 1, 1, '0);

    // sweep of every value (R2, R4, R6, R7, R8)
    for (int v = 0; v <= int'(ALL1); v++) begin
      step(0, 0, v[0], v[1], v[2], TW'(v));
      step(0, 1, 1, 0, 1, 0);
      step(0, 1, 1, 0, 0, 0);
      step(0, 1, 0, 1, 1, 0);
      step(0, 1, 0, 0, 1, 0);
      step(0, 0, 1, 1, 0, TW'(v));
      step(0, 1, 0, 0, 0, 0);
    end

    // reference sequence (R10)
    up_seq = '{ALL1 - 1, ALL1, 0, 1, 2};
    dn_seq = '{1, 0, ALL1, ALL1 - 1, ALL1 - 2};
    step(0, 0, 1, 1, 1, ALL1 - 2);
    chk(count_q == ALL1 - 2, "R10 preset", count_q, ALL1 - 2);
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 0, 0, 1, 0);
      chk(count_q == up_seq[i], "R10 up", count_q, up_seq[i]);
      chk(tc_n == (up_seq[i] != ALL1), "R10 up tc", TW'(tc_n), TW'(up_seq[i] != ALL1));
    end
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 1, 1, 1, 0);
      chk(count_q == 2, "R10 inhibit", count_q, 2);
    end
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 0, 0, 0, 0);
      chk(count_q == dn_seq[i], "R10 down", count_q, dn_seq[i]);
      chk(tc_n == (dn_seq[i] != 0), "R10 down tc", TW'(tc_n), TW'(dn_seq[i] != 0));
    end

    // random patterns, direction flips on terminal values (R4, R6, R8)
    for (int n = 0; n < 4000; n++) begin
      logic up;
      up = $urandom_range(0, 1) == 1;
      if (mdl == ALL1) up = ~up_dn;
      if (mdl == '0)   up = ~up_dn;
      step($urandom_range(0, 299) == 0, $urandom_range(0, 7) != 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, up,
           TW'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule